// File: doc/BRIEF.md
# Multi-Output Action-Qualified PWM Timer

This block generates three pairs of PWM outputs from a single time-base counter. The counter runs either up only, wrapping to zero after the period value, or up and then down, reversing at the period value and at zero. Two compare values set the edges. Each output has its own action table. For each counter event the table gives set, clear, toggle or no action. The events are counter at zero, counter at period, compare A match and compare B match, and each compare match has separate up and down entries. Because each output has a full table, one timer can produce edge-aligned, centre-aligned, complementary and window waveforms at the same time.

Software writes compare values into shadow registers. The counter uses those values once it returns to zero. An event-trigger stage counts period events and issues a one-clock interrupt pulse after a programmable number of them. The pulse falls at a known point in the PWM cycle, so the next compare values can be written safely. A pending flag is held until software clears it.

With a 50 MHz clock, a 10 kHz waveform needs a period of 4999 in up mode or 2500 in up-down mode.

Top module: `pwm_action_unit`

## Requirements
- R1: While reset is asserted, the counter is 0, the direction is up, all six outputs are low, the interrupt pulse and pending flag are low, and both active compare values are 0.
- R2: In up mode (`updown_i`=0) with `en_i` high, the counter steps 0,1,…,`prd_i` and then returns to 0, giving a period of `prd_i`+1 clocks. The direction stays up.
- R3: In up-down mode (`updown_i`=1) with `en_i` high, the counter rises to `prd_i`, then counts down to 0, then rises again, giving a period of 2·`prd_i` clocks. `dir_up_o` is low from the clock after the counter reaches `prd_i` until the clock after it reaches 0.
- R4: Each output has 12 configuration bits. Output i of pair A uses `act_a_i[12i+11:12i]` and output i of pair B uses `act_b_i[12i+11:12i]`. Bits [1:0] apply at zero, [3:2] at period, [5:4] on a compare A match while counting up, [7:6] on a compare A match while counting down, [9:8] on a compare B match while counting up, and [11:10] on a compare B match while counting down. Each 2-bit field encodes 00 = no action, 01 = drive low, 10 = drive high, 11 = invert.
- R5: An action takes effect on the clock edge that ends the cycle in which the counter holds the event value.
- R6: When several events with a non-zero field occur in the same cycle, only one applies. The priority order is compare B, then compare A, then zero, then period.
- R7: Writes to compare A and compare B go to shadow registers. The active value is loaded from the shadow at the end of every cycle in which the counter is 0.
- R8: While `en_i` is low, the counter and direction hold and no event is raised, so the outputs and the event-trigger state hold.
- R9: With `et_prescale_i`=P in the range 1..7, `irq_o` pulses for one clock after every P-th period event, provided the pending flag is clear. With P=0, no period events are counted and no pulse is issued.
- R10: A pulse sets `irq_pend_o`, which stays high until `et_clr_i` is asserted. While it is high, no pulse is issued: the event count stops at P−1, and the next period event after the clear fires at once.
- R11: In up mode the direction is always up, so the down-direction compare fields never act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter run enable |
| updown_i | input | 1 | 0 = up mode, 1 = up-down mode |
| prd_i | input | CW | Period value |
| cmpa_wr_i | input | 1 | Write strobe for compare A shadow |
| cmpa_i | input | CW | Compare A write data |
| cmpb_wr_i | input | 1 | Write strobe for compare B shadow |
| cmpb_i | input | CW | Compare B write data |
| act_a_i | input | 12·NPAIR | Action tables for the A outputs |
| act_b_i | input | 12·NPAIR | Action tables for the B outputs |
| et_prescale_i | input | 3 | Number of period events per interrupt (0 = off) |
| et_clr_i | input | 1 | Clears the pending flag |
| pwm_a_o | output | NPAIR | A outputs |
| pwm_b_o | output | NPAIR | B outputs |
| cnt_o | output | CW | Counter value |
| dir_up_o | output | 1 | Current count direction |
| irq_o | output | 1 | One-clock interrupt pulse |
| irq_pend_o | output | 1 | Interrupt pending flag |

## Verification
The bench goes after the cases where several events coincide. Compare A is set to zero so that it lands on the zero event, and both compare values are set equal. A design with the priority order reversed would show a full-duty pulse where the output should stay low. It also toggles a compare A shadow in the middle of a period. A design that loads the shadow at once, instead of at zero, would move an edge within the current period. Down-direction toggle fields are programmed in up mode, where any wrong direction qualification would flip the output. The bench also lets several prescale windows pass while the pending flag is still set. A design that ignores the flag would issue extra pulses, and one that keeps counting past the limit would delay the first pulse after the clear.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned ACT_W = 12;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef struct packed {
    logic zero;
    logic prd;
    logic ca_up;
    logic ca_dn;
    logic cb_up;
    logic cb_dn;
  } evt_t;

  function automatic logic apply_act(logic cur, act_e act);
    case (act)
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          updown_i,
  input  logic [CW-1:0] prd_i,
  output logic [CW-1:0] cnt_o,
  output logic          dir_up_o
);
  logic [CW-1:0] cnt_q;
  logic          up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (en_i) begin
      if (!updown_i) begin
        up_q  <= 1'b1;
        cnt_q <= (cnt_q >= prd_i) ? '0 : cnt_q + 1'b1;
      end else if (up_q) begin
        if (cnt_q >= prd_i) begin
          up_q  <= 1'b0;
          cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          up_q  <= 1'b1;
          cnt_q <= (prd_i == '0) ? '0 : CW'(1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_up_o = up_q;

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !updown_i && cnt_q == prd_i) |=> (cnt_q == '0));

  p_reverse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && updown_i && up_q && cnt_q == prd_i && prd_i != '0) |=> !up_q);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(up_q)));
endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          wr_a_i,
  input  logic [CW-1:0] din_a_i,
  input  logic          wr_b_i,
  input  logic [CW-1:0] din_b_i,
  output logic [CW-1:0] cmpa_o,
  output logic [CW-1:0] cmpb_o
);
  localparam int unsigned NCH = 2;

  logic [NCH-1:0]         wr;
  logic [NCH-1:0][CW-1:0] din, shd_q, act_q;

  assign wr  = {wr_b_i, wr_a_i};
  assign din = {din_b_i, din_a_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[c] <= '0;
        act_q[c] <= '0;
      end else begin
        if (wr[c])   shd_q[c] <= din[c];
        if (load_i)  act_q[c] <= shd_q[c];
      end
    end

    p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (act_q[c] == $past(shd_q[c])));

    p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(act_q[c]));
  end

  assign cmpa_o = act_q[0];
  assign cmpb_o = act_q[1];
endmodule

// File: rtl/pwm_act_qual.sv
module pwm_act_qual
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  evt_t             evt_i,
  input  logic [ACT_W-1:0] cfg_i,
  output logic             out_o
);
  act_e f_zero, f_prd, f_ca_up, f_ca_dn, f_cb_up, f_cb_dn, sel;
  logic out_q;

  assign f_zero  = act_e'(cfg_i[1:0]);
  assign f_prd   = act_e'(cfg_i[3:2]);
  assign f_ca_up = act_e'(cfg_i[5:4]);
  assign f_ca_dn = act_e'(cfg_i[7:6]);
  assign f_cb_up = act_e'(cfg_i[9:8]);
  assign f_cb_dn = act_e'(cfg_i[11:10]);

  // lowest priority first, later hits override
  always_comb begin
    sel = ACT_NONE;
    if (evt_i.prd   && f_prd   != ACT_NONE) sel = f_prd;
    if (evt_i.zero  && f_zero  != ACT_NONE) sel = f_zero;
    if (evt_i.ca_up && f_ca_up != ACT_NONE) sel = f_ca_up;
    if (evt_i.ca_dn && f_ca_dn != ACT_NONE) sel = f_ca_dn;
    if (evt_i.cb_up && f_cb_up != ACT_NONE) sel = f_cb_up;
    if (evt_i.cb_dn && f_cb_dn != ACT_NONE) sel = f_cb_dn;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= apply_act(out_q, sel);
  end

  assign out_o = out_q;

  p_noevt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0) |=> $stable(out_q));

  p_cb_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.cb_up && f_cb_up == ACT_CLR) |=> !out_q);

  p_dn_in_up_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_i.ca_up && evt_i.ca_dn));
endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig #(
  parameter int unsigned PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           prd_evt_i,
  input  logic [PSW-1:0] prescale_i,
  input  logic           clr_i,
  output logic           irq_o,
  output logic           pend_o
);
  logic [PSW-1:0] cnt_q;
  logic [PSW:0]   cnt_inc;
  logic           armed, reached, fire;
  logic           irq_q, pend_q;

  assign armed   = prd_evt_i && (prescale_i != '0);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign reached = cnt_inc >= {1'b0, prescale_i};
  assign fire    = armed && reached && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q <= fire;
      if (fire) begin
        cnt_q  <= '0;
        pend_q <= 1'b1;
      end else begin
        if (armed && !reached) cnt_q <= cnt_inc[PSW-1:0];
        if (clr_i)             pend_q <= 1'b0;
      end
    end
  end

  assign irq_o  = irq_q;
  assign pend_o = pend_q;

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  p_irq_sets_pend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> pend_q);

  p_pend_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> !irq_q);

  p_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prescale_i == '0) |=> !irq_q);
endmodule

// File: rtl/pwm_action_unit.sv
module pwm_action_unit
  import pwm_pkg::*;
#(
  parameter int unsigned CW    = 16,
  parameter int unsigned NPAIR = 3,
  parameter int unsigned PSW   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   updown_i,
  input  logic [CW-1:0]          prd_i,
  input  logic                   cmpa_wr_i,
  input  logic [CW-1:0]          cmpa_i,
  input  logic                   cmpb_wr_i,
  input  logic [CW-1:0]          cmpb_i,
  input  logic [NPAIR*ACT_W-1:0] act_a_i,
  input  logic [NPAIR*ACT_W-1:0] act_b_i,
  input  logic [PSW-1:0]         et_prescale_i,
  input  logic                   et_clr_i,
  output logic [NPAIR-1:0]       pwm_a_o,
  output logic [NPAIR-1:0]       pwm_b_o,
  output logic [CW-1:0]          cnt_o,
  output logic                   dir_up_o,
  output logic                   irq_o,
  output logic                   irq_pend_o
);
  logic [CW-1:0] cnt, cmpa, cmpb;
  logic          dir_up, at_zero, hit_a, hit_b;
  evt_t          evt;

  pwm_timebase #(.CW(CW)) i_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .updown_i(updown_i),
    .prd_i   (prd_i),
    .cnt_o   (cnt),
    .dir_up_o(dir_up)
  );

  assign at_zero = (cnt == '0);

  pwm_cmp_shadow #(.CW(CW)) i_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (at_zero),
    .wr_a_i (cmpa_wr_i),
    .din_a_i(cmpa_i),
    .wr_b_i (cmpb_wr_i),
    .din_b_i(cmpb_i),
    .cmpa_o (cmpa),
    .cmpb_o (cmpb)
  );

  assign hit_a     = en_i && (cnt == cmpa);
  assign hit_b     = en_i && (cnt == cmpb);
  assign evt.zero  = en_i && at_zero;
  assign evt.prd   = en_i && (cnt == prd_i);
  assign evt.ca_up = hit_a && dir_up;
  assign evt.ca_dn = hit_a && !dir_up;
  assign evt.cb_up = hit_b && dir_up;
  assign evt.cb_dn = hit_b && !dir_up;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    pwm_act_qual i_qa (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (evt),
      .cfg_i (act_a_i[i*ACT_W +: ACT_W]),
      .out_o (pwm_a_o[i])
    );
    pwm_act_qual i_qb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (evt),
      .cfg_i (act_b_i[i*ACT_W +: ACT_W]),
      .out_o (pwm_b_o[i])
    );
  end

  pwm_evt_trig #(.PSW(PSW)) i_et (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prd_evt_i (evt.prd),
    .prescale_i(et_prescale_i),
    .clr_i     (et_clr_i),
    .irq_o     (irq_o),
    .pend_o    (irq_pend_o)
  );

  assign cnt_o    = cnt;
  assign dir_up_o = dir_up;

  p_up_dir_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !updown_i) |=> dir_up);
endmodule

// File: tb/test_pwm_action_unit.sv
module test_pwm_action_unit;
  localparam int CW = 16;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, updown = 1'b0;
  logic [CW-1:0] prd = '0, cmpa_d = '0, cmpb_d = '0;
  logic cmpa_wr = 1'b0, cmpb_wr = 1'b0;
  logic [NP*12-1:0] act_a = '0, act_b = '0;
  logic [2:0] ps = '0;
  logic clr = 1'b0;
  logic [NP-1:0] pa, pb;
  logic [CW-1:0] cnt;
  logic dir_up, irq, pend;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  pwm_action_unit #(.CW(CW), .NPAIR(NP), .PSW(3)) i_pwm_action_unit (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .updown_i(updown), .prd_i(prd),
    .cmpa_wr_i(cmpa_wr), .cmpa_i(cmpa_d), .cmpb_wr_i(cmpb_wr), .cmpb_i(cmpb_d),
    .act_a_i(act_a), .act_b_i(act_b), .et_prescale_i(ps), .et_clr_i(clr),
    .pwm_a_o(pa), .pwm_b_o(pb), .cnt_o(cnt), .dir_up_o(dir_up),
    .irq_o(irq), .irq_pend_o(pend)
  );

  typedef struct {
    logic [CW-1:0] cnt;
    logic up;
    logic [NP-1:0] a, b;
    logic irq, pend;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [CW-1:0] m_cnt = '0, m_ca = '0, m_cb = '0, m_sa = '0, m_sb = '0;
  logic m_up = 1'b1, m_irq = 1'b0, m_pend = 1'b0;
  logic [NP-1:0] m_a = '0, m_b = '0;
  logic [2:0] m_et = '0;

  function automatic logic ref_out(logic cur, logic [11:0] f, logic z, logic p,
                                   logic au, logic ad, logic bu, logic bd);
    logic [1:0] a = 2'b00;
    if (bd && f[11:10] != 0) a = f[11:10];
    else if (bu && f[9:8] != 0) a = f[9:8];
    else if (ad && f[7:6] != 0) a = f[7:6];
    else if (au && f[5:4] != 0) a = f[5:4];
    else if (z && f[1:0] != 0) a = f[1:0];
    else if (p && f[3:2] != 0) a = f[3:2];
    case (a)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin : mdl
    logic z, p, ha, hb;
    logic [CW-1:0] n_cnt;
    logic n_up;
    exp_t e;
    if (!rst_ni) begin
      m_cnt = '0; m_up = 1'b1; m_a = '0; m_b = '0; m_ca = '0; m_cb = '0;
      m_sa = '0; m_sb = '0; m_et = '0; m_irq = 1'b0; m_pend = 1'b0;
    end else begin
      z  = en && m_cnt == 0;
      p  = en && m_cnt == prd;
      ha = en && m_cnt == m_ca;
      hb = en && m_cnt == m_cb;
      for (int i = 0; i < NP; i++) begin
        m_a[i] = ref_out(m_a[i], act_a[i*12 +: 12], z, p, ha && m_up, ha && !m_up,
                         hb && m_up, hb && !m_up);
        m_b[i] = ref_out(m_b[i], act_b[i*12 +: 12], z, p, ha && m_up, ha && !m_up,
                         hb && m_up, hb && !m_up);
      end
      n_cnt = m_cnt; n_up = m_up;
      if (en) begin
        if (!updown) begin
          n_up = 1'b1;
          n_cnt = (m_cnt >= prd) ? 0 : m_cnt + 1;
        end else if (m_up) begin
          if (m_cnt >= prd) begin n_up = 1'b0; n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else n_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin n_up = 1'b1; n_cnt = (prd == 0) ? 0 : 1; end
          else n_cnt = m_cnt - 1;
        end
      end
      if (m_cnt == 0) begin m_ca = m_sa; m_cb = m_sb; end
      if (cmpa_wr) m_sa = cmpa_d;
      if (cmpb_wr) m_sb = cmpb_d;
      m_irq = 1'b0;
      if (p && ps != 0) begin
        if (int'(m_et) + 1 >= int'(ps)) begin
          if (!m_pend) begin m_irq = 1'b1; m_pend = 1'b1; m_et = 0; end
        end else m_et = m_et + 1;
      end
      if (clr && !m_irq) m_pend = 1'b0;
      m_cnt = n_cnt; m_up = n_up;
      e.cnt = m_cnt; e.up = m_up; e.a = m_a; e.b = m_b; e.irq = m_irq; e.pend = m_pend;
      q.push_back(e);
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      if (rst_ni) begin
        chk("cnt", cnt, e.cnt);
        chk("dir", dir_up, e.up);
        chk("pwm_a", pa, e.a);
        chk("pwm_b", pb, e.b);
        chk("irq", irq, e.irq);
        chk("pend", pend, e.pend);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_cmp(int a, int b);
    cmpa_d = CW'(a); cmpb_d = CW'(b); cmpa_wr = 1'b1; cmpb_wr = 1'b1;
    cyc(1);
    cmpa_wr = 1'b0; cmpb_wr = 1'b0;
  endtask

  task automatic do_reset();
    en = 1'b0; rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  function automatic logic [11:0] f(int zero, int per, int au, int ad, int bu, int bd);
    return {2'(bd), 2'(bu), 2'(ad), 2'(au), 2'(per), 2'(zero)};
  endfunction

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #35;
    tag = "R1";
    chk("cnt", cnt, 0); chk("dir", dir_up, 1); chk("pwm_a", pa, 0);
    chk("pwm_b", pb, 0); chk("irq", irq, 0); chk("pend", pend, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    cyc(1);

    // R2 R4 R5 R11: up mode, mixed tables; A2 down fields toggle and must not act
    tag = "R2";
    prd = 9;
    act_a = {f(0,0,2,0,1,0), f(0,1,2,3,0,3), f(2,0,1,0,0,0)};
    act_b = {f(0,0,1,0,2,0), f(0,1,0,0,2,0), f(2,0,0,0,1,0)};
    wr_cmp(3, 6);
    ps = 5;
    en = 1'b1;
    cyc(30);
    tag = "R4"; cyc(20);
    tag = "R11"; cyc(20);
    // R7: shadow write mid-period lands at next zero
    tag = "R7";
    cyc(4);
    wr_cmp(7, 2);
    cyc(30);
    // R9 R10: pending blocks further pulses until cleared
    tag = "R10";
    cyc(60);
    clr = 1'b1; cyc(1); clr = 1'b0;
    tag = "R9"; cyc(70);
    // R8: disable holds everything
    tag = "R8";
    en = 1'b0; cyc(15);
    wr_cmp(4, 8);
    cyc(5);
    en = 1'b1; cyc(25);

    // R6: coincident events, compare A at zero and compare A equal to compare B
    do_reset();
    tag = "R6";
    updown = 1'b0; prd = 7;
    act_a = {f(0,0,2,0,1,0), f(0,1,0,0,2,0), f(2,0,1,0,0,0)};
    act_b = {f(0,0,1,0,2,0), f(3,0,0,0,0,0), f(2,0,0,0,1,0)};
    wr_cmp(0, 0);
    ps = 1;
    en = 1'b1; cyc(30);
    wr_cmp(5, 7);
    cyc(30);

    // R3: up-down mode, centre-aligned and toggle on zero and period
    do_reset();
    tag = "R3";
    updown = 1'b1; prd = 8;
    act_a = {f(0,0,0,0,0,0), f(3,3,0,0,0,0), f(0,0,2,1,0,0)};
    act_b = {f(0,0,0,0,0,0), f(0,0,0,0,0,0), f(0,0,0,0,2,1)};
    wr_cmp(2, 5);
    ps = 3;
    en = 1'b1; cyc(80);
    tag = "R10";
    cyc(40);
    clr = 1'b1; cyc(1); clr = 1'b0;
    tag = "R5"; cyc(60);
    // R9: prescale 0 never pulses
    tag = "R9";
    ps = 0;
    clr = 1'b1; cyc(1); clr = 1'b0;
    cyc(80);
    tag = "R9"; chk("irq_off", irq, 0);

    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule